// File: doc/BRIEF.md
# Memory-Mapped Storage Sector Reader

This block gives a small 16-bit processor a way to fetch one 512-byte sector from a storage controller without driving that controller itself. The processor loads a 28-bit logical block address into two registers and writes a positive number to a control/status register. The block then runs the whole device conversation on its own. It takes the device lock, sends the address and a read command, waits until the device buffer is ready, and moves the sector in 32-byte bursts into an internal RAM. Finally it releases the lock.

Software polls the control/status register. It reads zero while the transfer runs and turns negative (0x8000) once the sector is in the RAM. The sector is then read as 256 16-bit words through a data register. An 8-bit word pointer selects the word and advances by itself after every data read. Software can also write the pointer to reach any word directly.

Top module: `sector_reader`

## Requirements
- R1: After synchronous active-low reset, the control/status register reads 0, the word pointer reads 0 and `dev_req` is low.
- R2: Processor register 0 holds address bits 15:0. Register 1 holds bits 27:16 in its low 12 bits and reads back zero above them. The address sent to the device is the value present when the transfer starts: low half to device register 0x10, high half to 0x11.
- R3: Writing to control/status (processor register 3) a value with bit 15 clear and not zero starts a transfer. The register then reads 0 until completion and 0x8000 afterwards.
- R4: A control/status write of zero or of a value with bit 15 set has no effect. A start request while a transfer is running is also ignored.
- R5: The device sequence is fixed. (1) Write 1 to 0x18 to request the lock. (2) Read status 0x02 until bit 0 (lock granted) is set. (3) Write both address halves. (4) Write 0x0020 to 0x12 to issue the read command. (5) For each of 16 bursts, read 0x02 until bit 1 (buffer ready) is set, then read 0x40 sixteen times. (6) Write 0 to 0x18 to release the lock.
- R6: Each device access raises `dev_req` and holds it, with address and write data stable, until `dev_ack`. Only one access is outstanding at a time.
- R7: Reading the data register (processor register 4) returns the word at the pointer and then increments the pointer, which wraps from 255 to 0.
- R8: The pointer (processor register 2, 8 bits) can be written for random access. It is cleared to 0 when a transfer starts.
- R9: Word k of the sector RAM holds the k-th word read from device register 0x40 during the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_sel | input | 1 | Processor access strobe, one cycle per access |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | 3 | Register select: 0 address low, 1 address high, 2 pointer, 3 control/status, 4 data |
| cpu_wdata | input | 16 | Processor write data |
| cpu_rdata | output | 16 | Processor read data, valid in the cycle of the access |
| dev_req | output | 1 | Device access request, held until acknowledged |
| dev_we | output | 1 | Device access is a write |
| dev_addr | output | 7 | Device register address |
| dev_wdata | output | 16 | Device write data |
| dev_rdata | input | 16 | Device read data, valid with `dev_ack` |
| dev_ack | input | 1 | Device acknowledge, one cycle |

## Verification
The bench runs several sectors at random addresses against a device model with random acknowledge latency. The model also withholds lock-granted and buffer-ready for a random number of polls, so a design that skips a poll or reads data early is caught. Every word is a function of the address and its index, which separates a wrong address, a misplaced word or a missing burst. Sequential read-back checks the auto-increment and the wrap. Random pointer writes, including pointer 255, separate random access from sequential access. Directed writes of zero, of negative values and of a second start during a transfer show that these leave the device log and the status unchanged.

// File: rtl/sr_pkg.sv
// Shared constants and types for the sector reader.
// Assumes: device register map and status bit layout as listed below.
package sr_pkg;
    localparam logic [6:0]  DREG_STATUS = 7'h02;
    localparam logic [6:0]  DREG_LBA_LO = 7'h10;
    localparam logic [6:0]  DREG_LBA_HI = 7'h11;
    localparam logic [6:0]  DREG_CMD    = 7'h12;
    localparam logic [6:0]  DREG_LOCK   = 7'h18;
    localparam logic [6:0]  DREG_DATA   = 7'h40;
    localparam logic [15:0] CMD_READ    = 16'h0020;
    localparam int          ST_LOCK_BIT = 0;
    localparam int          ST_RDY_BIT  = 1;

    localparam logic [2:0]  CA_LBA_LO = 3'd0;
    localparam logic [2:0]  CA_LBA_HI = 3'd1;
    localparam logic [2:0]  CA_OFFSET = 3'd2;
    localparam logic [2:0]  CA_CTRL   = 3'd3;
    localparam logic [2:0]  CA_DATA   = 3'd4;

    typedef enum logic [3:0] {
        SQ_IDLE, SQ_LOCK, SQ_LOCK_POLL, SQ_LBA_LO, SQ_LBA_HI,
        SQ_CMD, SQ_RDY_POLL, SQ_BURST, SQ_UNLOCK, SQ_FINISH
    } seq_state_t;
endpackage

// File: rtl/sr_dev_port.sv
// Device access engine: turns a one-cycle command into a request held until
// the device acknowledges it, then returns a one-cycle done pulse with the
// read result kept in a hold register.
// Assumes: cmd_valid is only raised while no access is outstanding.
module sr_dev_port #(
    parameter int AW = 7,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_we,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    output logic          cmd_done,
    output logic [DW-1:0] cmd_rdata,
    output logic          dev_req,
    output logic          dev_we,
    output logic [AW-1:0] dev_addr,
    output logic [DW-1:0] dev_wdata,
    input  logic [DW-1:0] dev_rdata,
    input  logic          dev_ack
);
    logic busy;

    // Launch, hold and retire one device access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            cmd_done  <= 1'b0;
            dev_we    <= 1'b0;
            dev_addr  <= '0;
            dev_wdata <= '0;
            cmd_rdata <= '0;
        end else begin
            cmd_done <= 1'b0;
            if (!busy && cmd_valid) begin
                busy      <= 1'b1;
                dev_we    <= cmd_we;
                dev_addr  <= cmd_addr;
                dev_wdata <= cmd_wdata;
            end else if (busy && dev_ack) begin
                busy     <= 1'b0;
                cmd_done <= 1'b1;
                if (!dev_we) cmd_rdata <= dev_rdata;
            end
        end
    end

    assign dev_req = busy;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_req && !dev_ack) |=> (dev_req && $stable(dev_addr) && $stable(dev_wdata) && $stable(dev_we))); // R6
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !dev_req); // R6
endmodule

// File: rtl/sr_sector_seq.sv
// Sector fill sequencer: lock, address, command, ready polling, data bursts
// and unlock, one device access at a time through sr_dev_port.
// Assumes: start is only given while idle; the address is latched on start.
module sr_sector_seq
    import sr_pkg::*;
#(
    parameter int LBA_W       = 28,
    parameter int DW          = 16,
    parameter int AW          = 7,
    parameter int WORDS       = 256,
    parameter int BURST_WORDS = 16,
    localparam int IDX_W      = $clog2(WORDS),
    localparam int BCNT_W     = $clog2(BURST_WORDS),
    localparam int HI_W       = LBA_W - DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LBA_W-1:0] lba_in,
    output logic             busy,
    output logic             done,
    output logic             cmd_valid,
    output logic             cmd_we,
    output logic [AW-1:0]    cmd_addr,
    output logic [DW-1:0]    cmd_wdata,
    input  logic             cmd_done,
    input  logic [DW-1:0]    cmd_rdata,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [DW-1:0]    wr_data
);
    seq_state_t        state;
    logic              waiting;
    logic [LBA_W-1:0]  lba_q;
    logic [IDX_W-1:0]  widx;
    logic [BCNT_W-1:0] bcnt;

    // Choose the device access that belongs to the current step.
    always_comb begin
        cmd_we    = 1'b0;
        cmd_addr  = DREG_STATUS;
        cmd_wdata = '0;
        unique case (state)
            SQ_LOCK:   begin cmd_we = 1'b1; cmd_addr = DREG_LOCK; cmd_wdata = DW'(1); end
            SQ_LBA_LO: begin cmd_we = 1'b1; cmd_addr = DREG_LBA_LO; cmd_wdata = lba_q[DW-1:0]; end
            SQ_LBA_HI: begin cmd_we = 1'b1; cmd_addr = DREG_LBA_HI;
                             cmd_wdata = {{(DW-HI_W){1'b0}}, lba_q[LBA_W-1:DW]}; end
            SQ_CMD:    begin cmd_we = 1'b1; cmd_addr = DREG_CMD; cmd_wdata = CMD_READ; end
            SQ_BURST:  cmd_addr = DREG_DATA;
            SQ_UNLOCK: begin cmd_we = 1'b1; cmd_addr = DREG_LOCK; end
            default:   cmd_addr = DREG_STATUS;
        endcase
    end

    assign cmd_valid = (state != SQ_IDLE) && (state != SQ_FINISH) && !waiting;
    assign busy      = (state != SQ_IDLE);
    assign done      = (state == SQ_FINISH);
    assign wr_en     = (state == SQ_BURST) && cmd_done;
    assign wr_idx    = widx;
    assign wr_data   = cmd_rdata;

    // Step through the fill sequence as each access retires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SQ_IDLE;
            waiting <= 1'b0;
            lba_q   <= '0;
            widx    <= '0;
            bcnt    <= '0;
        end else if (state == SQ_IDLE) begin
            waiting <= 1'b0;
            if (start) begin
                lba_q <= lba_in;
                widx  <= '0;
                bcnt  <= '0;
                state <= SQ_LOCK;
            end
        end else if (state == SQ_FINISH) begin
            state <= SQ_IDLE;
        end else begin
            if (cmd_done)       waiting <= 1'b0;
            else if (cmd_valid) waiting <= 1'b1;
            if (cmd_done) begin
                unique case (state)
                    SQ_LOCK:      state <= SQ_LOCK_POLL;
                    SQ_LOCK_POLL: if (cmd_rdata[ST_LOCK_BIT]) state <= SQ_LBA_LO;
                    SQ_LBA_LO:    state <= SQ_LBA_HI;
                    SQ_LBA_HI:    state <= SQ_CMD;
                    SQ_CMD:       state <= SQ_RDY_POLL;
                    SQ_RDY_POLL:  if (cmd_rdata[ST_RDY_BIT]) state <= SQ_BURST;
                    SQ_BURST: begin
                        widx <= widx + 1'b1;
                        bcnt <= bcnt + 1'b1;
                        if (bcnt == BCNT_W'(BURST_WORDS - 1)) begin
                            state <= (widx == IDX_W'(WORDS - 1)) ? SQ_UNLOCK : SQ_RDY_POLL;
                        end
                    end
                    SQ_UNLOCK:    state <= SQ_FINISH;
                    default:      state <= SQ_IDLE;
                endcase
            end
        end
    end

    AST_DATA_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_BURST && $past(state) == SQ_RDY_POLL) |-> $past(cmd_rdata[ST_RDY_BIT])); // R5
    AST_ADDR_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_LBA_LO && $past(state) == SQ_LOCK_POLL) |-> $past(cmd_rdata[ST_LOCK_BIT])); // R5
    AST_UNLOCK_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_UNLOCK && $past(state) == SQ_BURST) |-> (widx == '0)); // R9
endmodule

// File: rtl/sr_sector_buf.sv
// Sector word store: one synchronous write port from the sequencer and one
// combinational read port for the processor data register.
// Assumes: WORDS is a power of two.
module sr_sector_buf #(
    parameter int WORDS = 256,
    parameter int DW    = 16,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DW-1:0]    rd_data
);
    logic [DW-1:0] mem [WORDS];

    // Store each word delivered by the device.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/sr_cpu_regs.sv
// Processor-facing registers: address halves, word pointer, control/status,
// and the data window with pointer auto-increment.
// Assumes: one-cycle accesses; read data is consumed in the access cycle.
module sr_cpu_regs
    import sr_pkg::*;
#(
    parameter int LBA_W = 28,
    parameter int DW    = 16,
    parameter int IDX_W = 8,
    localparam int HI_W = LBA_W - DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_sel,
    input  logic             cpu_we,
    input  logic [2:0]       cpu_addr,
    input  logic [DW-1:0]    cpu_wdata,
    output logic [DW-1:0]    cpu_rdata,
    input  logic             busy,
    input  logic             done,
    input  logic [DW-1:0]    buf_rdata,
    output logic             start,
    output logic [LBA_W-1:0] lba,
    output logic [IDX_W-1:0] rd_idx
);
    logic [DW-1:0]    lba_lo;
    logic [HI_W-1:0]  lba_hi;
    logic [IDX_W-1:0] offset;
    logic [DW-1:0]    status;
    logic             wr_acc, rd_acc;

    assign wr_acc = cpu_sel && cpu_we;
    assign rd_acc = cpu_sel && !cpu_we;
    assign start  = wr_acc && (cpu_addr == CA_CTRL) && !cpu_wdata[DW-1]
                    && (cpu_wdata != '0) && !busy;
    assign lba    = {lba_hi, lba_lo};
    assign rd_idx = offset;

    // Hold the block address written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lba_lo <= '0;
            lba_hi <= '0;
        end else if (wr_acc && cpu_addr == CA_LBA_LO) begin
            lba_lo <= cpu_wdata;
        end else if (wr_acc && cpu_addr == CA_LBA_HI) begin
            lba_hi <= cpu_wdata[HI_W-1:0];
        end
    end

    // Zero on start, negative on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)     status <= '0;
        else if (start) status <= '0;
        else if (done)  status <= {1'b1, {(DW-1){1'b0}}};
    end

    // Word pointer: cleared on start, loaded by software, bumped by data reads.
    always_ff @(posedge clk) begin
        if (!rst_n)                                offset <= '0;
        else if (start)                            offset <= '0;
        else if (wr_acc && cpu_addr == CA_OFFSET)  offset <= cpu_wdata[IDX_W-1:0];
        else if (rd_acc && cpu_addr == CA_DATA)    offset <= offset + 1'b1;
    end

    // Read-back multiplexer.
    always_comb begin
        unique case (cpu_addr)
            CA_LBA_LO: cpu_rdata = lba_lo;
            CA_LBA_HI: cpu_rdata = {{(DW-HI_W){1'b0}}, lba_hi};
            CA_OFFSET: cpu_rdata = {{(DW-IDX_W){1'b0}}, offset};
            CA_CTRL:   cpu_rdata = status;
            CA_DATA:   cpu_rdata = buf_rdata;
            default:   cpu_rdata = '0;
        endcase
    end

    AST_STATUS_ZERO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (status == '0)); // R3
    AST_DONE_NEGATIVE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> status[DW-1]); // R3
    AST_BAD_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && cpu_addr == CA_CTRL && !busy && (cpu_wdata == '0 || cpu_wdata[DW-1]))
        |=> ($stable(status) && !busy)); // R4
    AST_OFFSET_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && cpu_addr == CA_DATA && offset == '1) |=> (offset == '0)); // R7
    AST_START_CLEARS_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (offset == '0)); // R8
endmodule

// File: rtl/sector_reader.sv
// Top of the sector reader: processor registers, fill sequencer, device
// access engine and sector store.
// Assumes: one clock domain shared with the storage controller port.
module sector_reader #(
    parameter int LBA_W        = 28,
    parameter int DW           = 16,
    parameter int DEV_AW       = 7,
    parameter int SECTOR_BYTES = 512,
    parameter int BURST_BYTES  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_sel,
    input  logic              cpu_we,
    input  logic [2:0]        cpu_addr,
    input  logic [DW-1:0]     cpu_wdata,
    output logic [DW-1:0]     cpu_rdata,
    output logic              dev_req,
    output logic              dev_we,
    output logic [DEV_AW-1:0] dev_addr,
    output logic [DW-1:0]     dev_wdata,
    input  logic [DW-1:0]     dev_rdata,
    input  logic              dev_ack
);
    localparam int WORDS       = SECTOR_BYTES / (DW / 8);
    localparam int BURST_WORDS = BURST_BYTES / (DW / 8);
    localparam int IDX_W       = $clog2(WORDS);

    logic              start, busy, done;
    logic [LBA_W-1:0]  lba;
    logic [IDX_W-1:0]  rd_idx, wr_idx;
    logic [DW-1:0]     buf_rdata, wr_data, cmd_wdata, cmd_rdata;
    logic              wr_en, cmd_valid, cmd_we, cmd_done;
    logic [DEV_AW-1:0] cmd_addr;

    sr_cpu_regs #(.LBA_W(LBA_W), .DW(DW), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .busy(busy), .done(done), .buf_rdata(buf_rdata), .start(start),
        .lba(lba), .rd_idx(rd_idx)
    );

    sr_sector_seq #(.LBA_W(LBA_W), .DW(DW), .AW(DEV_AW), .WORDS(WORDS),
                    .BURST_WORDS(BURST_WORDS)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .lba_in(lba), .busy(busy),
        .done(done), .cmd_valid(cmd_valid), .cmd_we(cmd_we), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .cmd_done(cmd_done), .cmd_rdata(cmd_rdata),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    sr_dev_port #(.AW(DEV_AW), .DW(DW)) u_port (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_we(cmd_we),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_done(cmd_done),
        .cmd_rdata(cmd_rdata), .dev_req(dev_req), .dev_we(dev_we),
        .dev_addr(dev_addr), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata),
        .dev_ack(dev_ack)
    );

    sr_sector_buf #(.WORDS(WORDS), .DW(DW)) u_buf (
        .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(buf_rdata)
    );
endmodule

// File: tb/sim_sector_reader.sv
module sim_sector_reader;
    localparam int CLK_PERIOD = 10;
    localparam logic [6:0] D_STATUS = 7'h02, D_LBA_LO = 7'h10, D_LBA_HI = 7'h11,
                           D_CMD = 7'h12, D_LOCK = 7'h18, D_DATA = 7'h40;
    localparam logic [2:0] A_LO = 3'd0, A_HI = 3'd1, A_OFF = 3'd2, A_CTRL = 3'd3, A_DATA = 3'd4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cpu_sel = 1'b0, cpu_we = 1'b0;
    logic [2:0] cpu_addr = '0;
    logic [15:0] cpu_wdata = '0, cpu_rdata;
    logic dev_req, dev_we, dev_ack;
    logic [6:0] dev_addr;
    logic [15:0] dev_wdata, dev_rdata;

    int checks = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sector_reader u0 (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .dev_req(dev_req), .dev_we(dev_we), .dev_addr(dev_addr),
        .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .dev_ack(dev_ack)
    );

    function automatic logic [15:0] pat(input logic [27:0] lba, input int idx);
        return lba[15:0] ^ {lba[27:16], 4'h5} ^ 16'((idx * 16'h3C5B) + 17);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- device model ----------------
    logic [6:0] log_a [600];
    logic       log_w [600];
    logic [15:0] log_d [600];
    int log_n = 0, proto_err = 0, hs_err = 0;
    int wait_cnt = 0, dly = 1, lock_wait = 0, rdy_wait = 0, bcount = 0, widx = 0;
    bit lock_on = 0, cmd_seen = 0, rdy = 0, p_req = 0, p_ack = 0;
    logic [6:0] p_addr = '0;
    logic [27:0] cur_lba = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            dev_ack <= 1'b0;
            dev_rdata <= '0;
            p_req = 0; p_ack = 0; wait_cnt = 0;
        end else begin
            if (p_req && !p_ack && (!dev_req || dev_addr != p_addr)) hs_err++;
            p_req = dev_req; p_addr = dev_addr; p_ack = dev_ack;
            if (dev_ack) dev_ack <= 1'b0;
            else if (dev_req) begin
                if (wait_cnt >= dly) begin
                    logic [15:0] rd;
                    rd = '0;
                    wait_cnt = 0;
                    dly = int'($urandom % 4);
                    if (log_n < 600) begin
                        log_a[log_n] = dev_addr; log_w[log_n] = dev_we; log_d[log_n] = dev_wdata;
                        log_n++;
                    end
                    if (dev_we) begin
                        case (dev_addr)
                            D_LOCK: begin
                                lock_on = dev_wdata[0];
                                lock_wait = int'($urandom % 3);
                                if (!dev_wdata[0]) begin cmd_seen = 0; rdy = 0; end
                            end
                            D_LBA_LO: cur_lba[15:0] = dev_wdata;
                            D_LBA_HI: cur_lba[27:16] = dev_wdata[11:0];
                            D_CMD: begin cmd_seen = 1; rdy = 0; rdy_wait = int'($urandom % 4); bcount = 0; widx = 0; end
                            default: proto_err++;
                        endcase
                    end else if (dev_addr == D_STATUS) begin
                        if (lock_on && lock_wait > 0) lock_wait--;
                        if (cmd_seen && !rdy) begin
                            if (rdy_wait == 0) rdy = 1; else rdy_wait--;
                        end
                        rd = {14'b0, rdy, (lock_on && lock_wait == 0)};
                    end else if (dev_addr == D_DATA) begin
                        if (!rdy) proto_err++;
                        rd = pat(cur_lba, widx);
                        widx++; bcount++;
                        if (bcount == 16) begin bcount = 0; rdy = 0; rdy_wait = int'($urandom % 4); end
                    end else proto_err++;
                    dev_rdata <= rd;
                    dev_ack <= 1'b1;
                end else wait_cnt++;
            end
        end
    end

    // ---------------- processor access tasks ----------------
    task automatic cpu_wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(posedge clk); #1;
        cpu_sel = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic cpu_rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        #1 v = cpu_rdata;
        @(posedge clk); #1;
        cpu_sel = 1'b0;
    endtask

    task automatic wait_done(output logic [15:0] st);
        st = '0;
        for (int i = 0; i < 20000; i++) begin
            cpu_rd(A_CTRL, st);
            if (st[15]) break;
        end
    endtask

    // Walk the device log and confirm the fill sequence of R5 and R2.
    task automatic check_seq(input logic [27:0] lba);
        int i = 0, data_n = 0, bursts = 0;
        bit ok = 1;
        if (!(log_w[0] && log_a[0] == D_LOCK && log_d[0] == 16'h1)) ok = 0;
        i = 1;
        while (i < log_n && !log_w[i] && log_a[i] == D_STATUS) i++;
        if (!(log_w[i] && log_a[i] == D_LBA_LO)) ok = 0;
        chk(log_d[i] == lba[15:0], "R2 address low half to device", 32'(log_d[i]), 32'(lba[15:0]));
        i++;
        if (!(log_w[i] && log_a[i] == D_LBA_HI)) ok = 0;
        chk(log_d[i] == {4'b0, lba[27:16]}, "R2 address high half to device", 32'(log_d[i]), 32'(lba[27:16]));
        i++;
        if (!(log_w[i] && log_a[i] == D_CMD && log_d[i] == 16'h0020)) ok = 0;
        i++;
        while (i < log_n && data_n < 256) begin
            int run = 0;
            while (i < log_n && !log_w[i] && log_a[i] == D_STATUS) i++;
            while (i < log_n && !log_w[i] && log_a[i] == D_DATA) begin i++; run++; end
            if (run != 16) begin ok = 0; break; end
            data_n += run; bursts++;
        end
        if (!(i == log_n - 1 && log_w[i] && log_a[i] == D_LOCK && log_d[i] == 16'h0)) ok = 0;
        chk(ok && bursts == 16, "R5 device access order", 32'(bursts), 32'd16);
    endtask

    task automatic run_sector(input logic [27:0] lba, input bit extra_start);
        logic [15:0] v;
        int bad = 0;
        log_n = 0;
        cpu_wr(A_LO, lba[15:0]);
        cpu_wr(A_HI, {4'b0, lba[27:16]});
        cpu_wr(A_OFF, 16'd77);
        cpu_rd(A_OFF, v);
        chk(v == 16'd77, "R8 pointer write", 32'(v), 32'd77);
        cpu_wr(A_CTRL, 16'(1 + ($urandom % 16'h7FFE)));
        cpu_rd(A_OFF, v);
        chk(v == 16'd0, "R8 pointer cleared by start", 32'(v), 32'd0);
        cpu_rd(A_CTRL, v);
        chk(v == 16'd0, "R3 status zero while busy", 32'(v), 32'd0);
        if (extra_start) begin
            cpu_wr(A_CTRL, 16'h0005);   // R4: ignored while busy
            cpu_wr(A_LO, 16'hFFFF);     // address latched at start (R2)
        end
        wait_done(v);
        chk(v == 16'h8000, "R3 status negative at completion", 32'(v), 32'h8000);
        check_seq(lba);
        chk(proto_err == 0, "R5 no data read before ready", 32'(proto_err), 32'd0);
        chk(hs_err == 0, "R6 request held until acknowledge", 32'(hs_err), 32'd0);
        cpu_wr(A_OFF, 16'd0);
        for (int k = 0; k < 256; k++) begin
            cpu_rd(A_DATA, v);
            if (v != pat(lba, k)) begin
                bad++;
                chk(0, "R9 sector word", 32'(v), 32'(pat(lba, k)));
            end
        end
        chk(bad == 0, "R7 sequential read of all 256 words", 32'(bad), 32'd0);
        cpu_rd(A_OFF, v);
        chk(v == 16'd0, "R7 pointer wraps to 0 after 256 reads", 32'(v), 32'd0);
        for (int k = 0; k < 6; k++) begin
            int off = int'($urandom % 256);
            cpu_wr(A_OFF, 16'(off));
            cpu_rd(A_DATA, v);
            chk(v == pat(lba, off), "R8 random access word", 32'(v), 32'(pat(lba, off)));
            cpu_rd(A_OFF, v);
            chk(v == 16'((off + 1) % 256), "R7 pointer increments after data read", 32'(v), 32'((off + 1) % 256));
        end
    endtask

    // ---------------- main sequence ----------------
    initial begin
        logic [15:0] v;
        void'($urandom(32'h5EC7_0A11));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(dev_req == 1'b0, "R1 no device request after reset", 32'(dev_req), 32'd0);
        cpu_rd(A_CTRL, v);
        chk(v == 16'd0, "R1 status zero after reset", 32'(v), 32'd0);
        cpu_rd(A_OFF, v);
        chk(v == 16'd0, "R1 pointer zero after reset", 32'(v), 32'd0);

        cpu_wr(A_LO, 16'hBEEF);
        cpu_wr(A_HI, 16'hFABC);
        cpu_rd(A_LO, v);
        chk(v == 16'hBEEF, "R2 address low readback", 32'(v), 32'hBEEF);
        cpu_rd(A_HI, v);
        chk(v == 16'h0ABC, "R2 address high readback masked", 32'(v), 32'h0ABC);

        log_n = 0;
        cpu_wr(A_CTRL, 16'h0000);
        cpu_wr(A_CTRL, 16'h8000);
        cpu_wr(A_CTRL, 16'hFFFF);
        repeat (20) @(posedge clk);
        #1;
        chk(log_n == 0, "R4 zero/negative writes start nothing", 32'(log_n), 32'd0);
        cpu_rd(A_CTRL, v);
        chk(v == 16'd0, "R4 status unchanged by ignored writes", 32'(v), 32'd0);

        run_sector(28'hABC_BEEF, 1'b1);
        log_n = 0;
        cpu_wr(A_CTRL, 16'h8001);
        repeat (10) @(posedge clk);
        #1;
        chk(log_n == 0, "R4 negative write after completion ignored", 32'(log_n), 32'd0);
        cpu_rd(A_CTRL, v);
        chk(v == 16'h8000, "R4 status kept after ignored write", 32'(v), 32'h8000);

        for (int s = 0; s < 3; s++) run_sector(28'($urandom), s[0]);
        run_sector(28'h0000000, 1'b0);

        cpu_wr(A_OFF, 16'd255);
        cpu_rd(A_DATA, v);
        chk(v == pat(28'h0, 255), "R7 read at pointer 255", 32'(v), 32'(pat(28'h0, 255)));
        cpu_rd(A_OFF, v);
        chk(v == 16'd0, "R7 pointer wraps 255 to 0", 32'(v), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        checks++; fails++;
        $display("FAIL watchdog timeout");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule